// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is the slave side of a three-wire serial EEPROM. It has a chip select, a serial clock, a data input and a data output. The output is modelled as a data bit plus an enable flag. All serial pins are sampled by a faster system clock. The block finds a start bit, shifts in an opcode, an address and, when the command needs it, write data. It then carries out one of seven commands on a small on-chip byte array.

The array can be seen either as 16-bit words or as 8-bit bytes, chosen by an organization input. Array writes are guarded two ways:

- A write-enable latch that only the enable and disable commands change. It comes out of reset disabled.
- A program-enable pin.

A write or erase command starts a programming cycle of fixed length when chip select falls. During that cycle new commands are ignored. A host that raises chip select can poll the data output to see whether the cycle is still running.

Top module: `mwire_eeprom`

## Requirements
- R1: All serial inputs are taken on rising edges of the serial clock. A frame is: one start bit, a 2-bit opcode, then the address, then (for the two write forms) the data. The opcode codes are 10 read, 01 write, 11 erase, 00 extended. The address is AW16 bits in word mode and AW16+1 bits in byte mode. Address and data are sent MSB first. Data is 16 bits in word mode and 8 bits in byte mode.
- R2: The start bit is the first rising serial edge at which chip select and data-in are both high. Zero bits before it, and any pin activity while chip select is low, start nothing.
- R3: A frame in which chip select falls before every bit the command needs has arrived is dropped, with no effect on the array or the output.
- R4: The output enable is low whenever chip select is low. With chip select high, it is raised only for read data or for programming status.
- R5: Once a programming cycle has started, raising chip select drives the output low while the cycle runs and high once it is over. This lasts until a new start bit arrives, or until chip select falls with the cycle finished.
- R6: A read drives a zero bit on the edge that takes the last address bit. The next edges then drive the data bits MSB first, one per edge. The enable drops on the edge after the last data bit.
- R7: After reset, writes are disabled. The extended command selects its variant with the two top address bits. Code 11 enables writes and code 00 disables them, each taking effect when chip select falls.
- R8: While writes are disabled, the write, erase, erase-all and write-all commands change nothing and start no programming cycle.
- R9: In word mode, word a occupies bytes 2a (high half) and 2a+1 (low half). Byte mode addresses the same bytes one at a time.
- R10: With program-enable low, no command changes the array and no programming cycle starts, whatever the state of the write-enable latch.
- R11: Erase sets the addressed word or byte to all ones. Extended code 10 sets every byte to all ones. Extended code 01 writes its data to every word or byte.
- R12: A programming cycle lasts PROG_CYCLES system clocks, counted from the fall of chip select. Start bits sent during it are ignored.
- R13: Reset sets every array byte to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mw_cs | input | 1 | Chip select, active high |
| mw_clk | input | 1 | Serial clock |
| mw_din | input | 1 | Serial data in |
| wide_org | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| prog_en | input | 1 | Program enable; low blocks array changes |
| mw_dout | output | 1 | Serial data out / ready-busy status |
| mw_dout_en | output | 1 | Output enable for mw_dout |

## Verification
Some properties are checked by assertions on every cycle:

- Frames only leave idle on a qualified start bit.
- The array never takes a write with program-enable low.
- Programming cycles begin only with writes enabled, and never overlap a start.
- Status reads low while busy.
- Read output stops once chip select falls.

Other behaviour can only be shown by the bench scenarios: the bit-level frame order, the word and byte mapping, dropped partial frames, the cycle length, and what ends up stored after each command sequence.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

    localparam int ADDR_MAX = 8;
    localparam int WORD_W   = 16;

    typedef enum logic [2:0] {
        F_IDLE, F_OPC, F_ADR, F_DAT, F_READ, F_DONE
    } fstate_t;

    typedef enum logic [2:0] {
        C_NONE, C_READ, C_WRITE, C_ERASE, C_EWEN, C_EWDS, C_ERAL, C_WRAL
    } cmd_t;

    typedef struct packed {
        cmd_t                cmd;
        logic [ADDR_MAX-1:0] addr;
        logic [WORD_W-1:0]   data;
    } frame_t;

    function automatic cmd_t decode_cmd(input logic [1:0] opc, input logic [1:0] ext);
        case (opc)
            2'b10:   return C_READ;
            2'b01:   return C_WRITE;
            2'b11:   return C_ERASE;
            default: begin
                case (ext)
                    2'b11:   return C_EWEN;
                    2'b00:   return C_EWDS;
                    2'b10:   return C_ERAL;
                    default: return C_WRAL;
                endcase
            end
        endcase
    endfunction

    function automatic logic is_prog(input cmd_t c);
        return (c == C_WRITE) || (c == C_ERASE) || (c == C_ERAL) || (c == C_WRAL);
    endfunction

endpackage

// File: rtl/mwire_frame.sv
module mwire_frame
    import mwire_pkg::*;
#(
    parameter int AW16 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                org16,
    input  logic                hold,
    output frame_t              fr,
    output logic                done,
    output logic                rd_load,
    output logic                started,
    output logic [ADDR_MAX-1:0] addr_next,
    output logic                sk_rise,
    output logic                cs_fall
);
    localparam int AW8 = AW16 + 1;

    fstate_t    st;
    logic [4:0] cnt;
    logic [1:0] opc;
    logic       sk_q, cs_q;
    logic [4:0] aw, dw;
    logic [1:0] ext;
    cmd_t       cmd_nx;
    logic       last_adr;

    always_comb begin
        sk_rise   = sclk & ~sk_q;
        cs_fall   = cs_q & ~cs;
        aw        = org16 ? 5'(AW16) : 5'(AW8);
        dw        = org16 ? 5'd16 : 5'd8;
        addr_next = {fr.addr[ADDR_MAX-2:0], sdi};
        ext       = {addr_next[3'(aw - 5'd1)], addr_next[3'(aw - 5'd2)]};
        cmd_nx    = decode_cmd(opc, ext);
        last_adr  = (st == F_ADR) && (cnt == aw - 5'd1);
        rd_load   = cs & sk_rise & last_adr & (cmd_nx == C_READ);
        started   = cs & sk_rise & (st == F_IDLE) & sdi & ~hold;
        done      = (st == F_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= F_IDLE;
            cnt  <= '0;
            opc  <= '0;
            sk_q <= 1'b0;
            cs_q <= 1'b0;
            fr   <= '0;
        end else begin
            sk_q <= sclk;
            cs_q <= cs;
            if (!cs) begin
                st <= F_IDLE;
            end else if (sk_rise) begin
                unique case (st)
                    F_IDLE: if (started) begin
                        st  <= F_OPC;
                        cnt <= '0;
                        opc <= '0;
                        fr  <= '0;
                    end
                    F_OPC: begin
                        opc <= {opc[0], sdi};
                        if (cnt == 5'd1) begin
                            st  <= F_ADR;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 5'd1;
                        end
                    end
                    F_ADR: begin
                        fr.addr <= addr_next;
                        if (last_adr) begin
                            fr.cmd <= cmd_nx;
                            cnt    <= '0;
                            if (cmd_nx == C_READ)
                                st <= F_READ;
                            else if (cmd_nx == C_WRITE || cmd_nx == C_WRAL)
                                st <= F_DAT;
                            else
                                st <= F_DONE;
                        end else begin
                            cnt <= cnt + 5'd1;
                        end
                    end
                    F_DAT: begin
                        fr.data <= {fr.data[WORD_W-2:0], sdi};
                        if (cnt == dw - 5'd1) st <= F_DONE;
                        else                  cnt <= cnt + 5'd1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a frame leaves idle only on a rising serial edge with CS and DI high
    a_r2_start_qualified: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == F_IDLE && st != F_IDLE) |-> $past(cs && sdi && sk_rise));

endmodule

// File: rtl/mwire_array.sv
module mwire_array
    import mwire_pkg::*;
#(
    parameter int AW16 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                org16,
    input  logic                wr_go,
    input  cmd_t                cmd,
    input  logic [ADDR_MAX-1:0] waddr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                prog_en,
    input  logic [ADDR_MAX-1:0] raddr,
    output logic [WORD_W-1:0]   rd_word
);
    localparam int NB = 2 ** (AW16 + 1);

    logic [7:0] mem [NB];
    logic       whole, fill_ones;

    assign whole     = (cmd == C_ERAL) || (cmd == C_WRAL);
    assign fill_ones = (cmd == C_ERASE) || (cmd == C_ERAL);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        localparam logic [AW16-1:0] WIDX = (AW16)'(g / 2);
        localparam logic [AW16:0]   BIDX = (AW16 + 1)'(g);
        logic       sel, hit;
        logic [7:0] val;
        always_comb begin
            sel = org16 ? (waddr[AW16-1:0] == WIDX) : (waddr[AW16:0] == BIDX);
            hit = whole || sel;
            if (fill_ones)                 val = 8'hFF;
            else if (org16 && (g % 2 == 0)) val = wdata[15:8];
            else                           val = wdata[7:0];
        end
        always_ff @(posedge clk) begin
            if (rst)               mem[g] <= 8'hFF;
            else if (wr_go && hit) mem[g] <= val;
        end
    end

    logic [AW16:0] hi_idx, lo_idx;
    always_comb begin
        hi_idx  = {raddr[AW16-1:0], 1'b0};
        lo_idx  = {raddr[AW16-1:0], 1'b1};
        rd_word = org16 ? {mem[hi_idx], mem[lo_idx]} : {mem[raddr[AW16:0]], 8'h00};
    end

    // R10: the array never takes a write while program-enable is low
    a_r10_pe_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> prog_en);

endmodule

// File: rtl/mwire_prog.sv
module mwire_prog #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic cs_fall,
    input  logic restart,
    output logic busy,
    output logic status_on
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (launch) begin
            cnt  <= CW'(PROG_CYCLES);
            pend <= 1'b1;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (restart || (cs_fall && cnt == '0)) pend <= 1'b0;
        end
    end

    assign busy      = (cnt != '0);
    assign status_on = pend;

    // R12: a cycle only begins after a launch, and no start is taken while busy
    a_r12_busy_from_launch: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch));
    a_r12_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !restart);

endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
    import mwire_pkg::*;
#(
    parameter int AW16        = 4,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic mw_cs,
    input  logic mw_clk,
    input  logic mw_din,
    input  logic wide_org,
    input  logic prog_en,
    output logic mw_dout,
    output logic mw_dout_en
);
    frame_t              fr;
    logic                done, rd_load, started, sk_rise, cs_fall;
    logic [ADDR_MAX-1:0] addr_next;
    logic [WORD_W-1:0]   rd_word;
    logic                busy, status_on, commit, launch, we_en;
    logic [WORD_W:0]     rd_sh;
    logic [4:0]          rd_left;
    logic                rd_on;

    mwire_frame #(.AW16(AW16)) u_frame (
        .clk(clk), .rst(rst), .cs(mw_cs), .sclk(mw_clk), .sdi(mw_din),
        .org16(wide_org), .hold(busy), .fr(fr), .done(done),
        .rd_load(rd_load), .started(started), .addr_next(addr_next),
        .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    assign commit = cs_fall & done;
    assign launch = commit & is_prog(fr.cmd) & we_en & prog_en;

    mwire_array #(.AW16(AW16)) u_array (
        .clk(clk), .rst(rst), .org16(wide_org), .wr_go(launch),
        .cmd(fr.cmd), .waddr(fr.addr), .wdata(fr.data), .prog_en(prog_en),
        .raddr(addr_next), .rd_word(rd_word)
    );

    mwire_prog #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst(rst), .launch(launch), .cs_fall(cs_fall),
        .restart(started), .busy(busy), .status_on(status_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_en <= 1'b0;
        end else if (commit) begin
            if (fr.cmd == C_EWEN)      we_en <= 1'b1;
            else if (fr.cmd == C_EWDS) we_en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sh   <= '0;
            rd_left <= '0;
            rd_on   <= 1'b0;
        end else if (!mw_cs) begin
            rd_on <= 1'b0;
        end else if (rd_load) begin
            rd_sh   <= {1'b0, rd_word};
            rd_left <= wide_org ? 5'd17 : 5'd9;
            rd_on   <= 1'b1;
        end else if (rd_on && sk_rise) begin
            if (rd_left == 5'd1) begin
                rd_on <= 1'b0;
            end else begin
                rd_sh   <= {rd_sh[WORD_W-1:0], 1'b0};
                rd_left <= rd_left - 5'd1;
            end
        end
    end

    assign mw_dout_en = mw_cs & (rd_on | status_on);
    assign mw_dout    = rd_on ? rd_sh[WORD_W] : ~busy;

    // R5: while programming, an enabled output reads low
    a_r5_busy_reads_low: assert property (@(posedge clk) disable iff (rst)
        (busy && mw_dout_en) |-> !mw_dout);
    // R6: read output stops once chip select has fallen
    a_r6_read_stops_on_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(mw_cs) |=> !rd_on);
    // R7: write enable only rises after a frame ended with chip select low
    a_r7_enable_on_cs_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(we_en) |-> !$past(mw_cs));
    // R8: a programming cycle needs writes enabled
    a_r8_busy_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(we_en));

endmodule

// File: tb/tb_mwire_eeprom.sv
module tb_mwire_eeprom;
    localparam int AW16 = 4;
    localparam int PROG = 200;
    localparam int NB   = 2 ** (AW16 + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic mw_cs = 1'b0, mw_clk = 1'b0, mw_din = 1'b0, wide_org = 1'b1, prog_en = 1'b1;
    logic mw_dout, mw_dout_en;

    int nchk = 0, nfail = 0;
    logic [7:0] m [NB];

    mwire_eeprom #(.AW16(AW16), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_din(mw_din),
        .wide_org(wide_org), .prog_en(prog_en), .mw_dout(mw_dout), .mw_dout_en(mw_dout_en)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic o, output logic oe);
        mw_din = b; mw_clk = 1'b0;
        idle(4);
        mw_clk = 1'b1;
        idle(2);
        o = mw_dout; oe = mw_dout_en;
        idle(2);
    endtask

    task automatic csup();
        mw_cs = 1'b1; mw_clk = 1'b0; mw_din = 1'b0;
        idle(2);
    endtask

    task automatic csdn();
        mw_clk = 1'b0; mw_cs = 1'b0; mw_din = 1'b0;
        idle(3);
    endtask

    task automatic head(input logic [1:0] opc, input logic [7:0] a, input int aw,
                        output logic o, output logic oe);
        sbit(1'b1, o, oe);
        sbit(opc[1], o, oe);
        sbit(opc[0], o, oe);
        for (int i = aw - 1; i >= 0; i--) sbit(a[i], o, oe);
    endtask

    function automatic int awid();
        return wide_org ? AW16 : AW16 + 1;
    endfunction

    function automatic int dwid();
        return wide_org ? 16 : 8;
    endfunction

    function automatic logic [7:0] ext_a(input logic [1:0] code);
        return 8'(code) << (awid() - 2);
    endfunction

    // send a command frame; nbits limits the data bits sent (partial frames)
    task automatic frame(input logic [1:0] opc, input logic [7:0] a,
                         input logic [15:0] d, input int nbits);
        logic o, oe;
        csup();
        head(opc, a, awid(), o, oe);
        for (int i = dwid() - 1; i >= dwid() - nbits; i--) sbit(d[i], o, oe);
        csdn();
    endtask

    task automatic wr(input logic [1:0] opc, input logic [7:0] a, input logic [15:0] d);
        frame(opc, a, d, (opc == 2'b01 || (opc == 2'b00 && a == ext_a(2'b01))) ? dwid() : 0);
        idle(PROG + 10);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        logic o, oe;
        v = '0;
        csup();
        head(2'b10, a, awid(), o, oe);
        chk("R6 dummy zero", {oe, o}, 2'b10);
        for (int i = 0; i < dwid(); i++) begin
            sbit(1'b0, o, oe);
            v = {v[14:0], o};
        end
        sbit(1'b0, o, oe);
        chk("R6 enable off after last bit", oe, 0);
        csdn();
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        if (wide_org) return {m[{a[AW16-1:0], 1'b0}], m[{a[AW16-1:0], 1'b1}]};
        return {8'h00, m[a[AW16:0]]};
    endfunction

    task automatic wr_model(input logic [7:0] a, input logic [15:0] d);
        if (wide_org) begin
            m[{a[AW16-1:0], 1'b0}] = d[15:8];
            m[{a[AW16-1:0], 1'b1}] = d[7:0];
        end else begin
            m[a[AW16:0]] = d[7:0];
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp_rd(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic o, oe;
        int n;
        for (int i = 0; i < NB; i++) m[i] = 8'hFF;
        idle(5);
        rst = 1'b0;
        idle(2);
        chk("R4 enable low after reset", mw_dout_en, 0);

        // R13: blank array reads all ones
        rd_chk("R13 reset contents", 8'd0);
        rd_chk("R13 reset contents", 8'd15);

        // R8: write ignored while disabled, no status
        wr(2'b01, 8'd3, 16'h1234);
        csup();
        chk("R8 no status when disabled", mw_dout_en, 0);
        csdn();
        rd_chk("R8 disabled write", 8'd3);

        // R7: enable, then write with status polling (R5, R12)
        wr(2'b00, ext_a(2'b11), 16'h0);
        frame(2'b01, 8'd2, 16'hBEEF, 16);
        wr_model(8'd2, 16'hBEEF);
        csup();
        chk("R5 busy status low", {mw_dout_en, mw_dout}, 2'b10);
        n = 0;
        while (mw_dout !== 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R12 cycle length window", (n >= PROG - 8 && n <= PROG - 2), 1);
        chk("R5 ready status high", {mw_dout_en, mw_dout}, 2'b11);
        csdn();
        chk("R4 enable off on cs fall", mw_dout_en, 0);
        rd_chk("R7 write after enable", 8'd2);

        // R1/R9: word sweep
        for (int a = 0; a < 16; a++) begin
            logic [15:0] d;
            d = 16'(a * 16'h1357) ^ 16'hA5C3;
            wr(2'b01, 8'(a), d);
            wr_model(8'(a), d);
        end
        for (int a = 0; a < 16; a++) rd_chk("R1 word read", 8'(a));

        // R9: byte view of the same array
        wide_org = 1'b0;
        for (int b = 0; b < NB; b++) rd_chk("R9 byte read", 8'(b));
        wr(2'b01, 8'd7, 16'h005E);  wr_model(8'd7, 16'h005E);
        wr(2'b01, 8'd20, 16'h00C1); wr_model(8'd20, 16'h00C1);
        wide_org = 1'b1;
        rd_chk("R9 byte write in word", 8'd3);
        rd_chk("R9 byte write in word", 8'd10);

        // R11: erase one word
        wr(2'b11, 8'd5, 16'h0);
        wr_model(8'd5, 16'hFFFF);
        rd_chk("R11 erase word", 8'd5);

        // R3: partial write dropped
        frame(2'b01, 8'd6, 16'h0000, 10);
        csup();
        chk("R3 no status after partial", mw_dout_en, 0);
        csdn();
        rd_chk("R3 partial frame", 8'd6);

        // R2: noise with cs low, then leading zeros
        for (int i = 0; i < 4; i++) begin
            mw_din = 1'b1; mw_clk = 1'b1; idle(3);
            mw_clk = 1'b0; idle(3);
        end
        chk("R2 no output before start", mw_dout_en, 0);
        csup();
        sbit(1'b0, o, oe);
        sbit(1'b0, o, oe);
        sbit(1'b0, o, oe);
        chk("R2 leading zeros idle", oe, 0);
        head(2'b10, 8'd4, AW16, o, oe);
        chk("R2 read after zeros dummy", {oe, o}, 2'b10);
        csdn();
        rd_chk("R2 noise changed nothing", 8'd4);

        // R10: program-enable low
        prog_en = 1'b0;
        wr(2'b01, 8'd1, 16'h0F0F);
        csup();
        chk("R10 no status with pe low", mw_dout_en, 0);
        csdn();
        prog_en = 1'b1;
        rd_chk("R10 pe blocks write", 8'd1);

        // R12: frame during busy ignored
        frame(2'b01, 8'd8, 16'h8888, 16);
        wr_model(8'd8, 16'h8888);
        frame(2'b01, 8'd9, 16'h0000, 16);
        idle(PROG + 10);
        rd_chk("R12 write taken", 8'd8);
        rd_chk("R12 busy frame ignored", 8'd9);

        // R4/R6: read cut mid-stream
        csup();
        head(2'b10, 8'd2, AW16, o, oe);
        sbit(1'b0, o, oe);
        sbit(1'b0, o, oe);
        csdn();
        chk("R4 read enable off on cs fall", mw_dout_en, 0);

        // R11: write-all then erase-all
        wr(2'b00, ext_a(2'b01), 16'h5AA5);
        for (int b = 0; b < NB; b++) m[b] = (b % 2 == 0) ? 8'h5A : 8'hA5;
        for (int a = 0; a < 16; a += 5) rd_chk("R11 write-all", 8'(a));
        wr(2'b00, ext_a(2'b10), 16'h0);
        for (int b = 0; b < NB; b++) m[b] = 8'hFF;
        for (int a = 0; a < 16; a += 5) rd_chk("R11 erase-all", 8'(a));
        wide_org = 1'b0;
        wr(2'b00, ext_a(2'b01), 16'h003C);
        for (int b = 0; b < NB; b++) m[b] = 8'h3C;
        rd_chk("R11 byte write-all", 8'd0);
        rd_chk("R11 byte write-all", 8'd31);
        wide_org = 1'b1;

        // R7: disable again
        wr(2'b00, ext_a(2'b00), 16'h0);
        wr(2'b01, 8'd0, 16'h0000);
        rd_chk("R7 disabled after EWDS", 8'd0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule